// File: doc/BRIEF.md
# Aging Layer-2 Forwarding Table

This block is a small, fully associative table of layer-2 addresses. It maps a key made of a 48-bit MAC address and a 12-bit VLAN ID to a destination port mask. A lookup port returns the mask for a destination, or a flood mask when nothing matches. A learning port records the source address of a frame seen on an ingress port. A static-write port installs protected entries and can delete them again.

Every entry carries a 2-bit age code and three protection flags: static, authenticated and IP-multicast. The age code counts down a Gray-coded sequence: 2'b10 is newest, then 2'b11, then 2'b01, then 2'b00. Code 2'b00 marks a free slot. A periodic age tick moves every unprotected entry one step down this sequence. A per-port fast-age command frees the learned entries that belong to the selected ports. Entries that carry any protection flag never age and are never flushed or replaced.

Top module: `l2_age_table`

## Requirements
- R1: When `lk_valid` is high at a clock edge, `lk_rsp` is 1 after that edge. A lookup hits only a non-free entry whose MAC and VLAN both equal the lookup key. A hit gives `lk_miss`=0 and `lk_mask` equal to the mask stored in that entry.
- R2: A lookup that matches no non-free entry gives `lk_miss`=1 and an all-ones `lk_mask` covering NUM_PORTS bits.
- R3: Learning a key that is not in the table writes it with mask `1<<learn_port`, age 2'b10 and all protection flags clear. The key goes into the lowest-indexed free slot if one exists.
- R4: Learning a key that is already held by an unprotected entry refreshes that entry in place. Its age becomes 2'b10 and its mask becomes `1<<learn_port`. No other slot is used.
- R5: Each age tick steps every unprotected, non-free entry from 2'b10 to 2'b11, from 2'b11 to 2'b01, and from 2'b01 to 2'b00. A learned entry therefore misses after its third tick with no refresh. Free slots stay at 2'b00.
- R6: When no slot is free, a learn replaces an unprotected entry. It picks the oldest age first (2'b01 before 2'b11 before 2'b10), and the lowest index among entries of equal age.
- R7: An entry with any protection flag keeps age 2'b10 and is never aged, flushed or replaced. If a new key is inserted while every slot is protected, the table does not change and `ins_fail` is 1 for exactly the one cycle after that edge.
- R8: A fast-age command with bit p set in `flush_ports` frees, in one cycle, every unprotected entry whose mask has exactly one bit set and that bit is set in `flush_ports`. All other entries are unchanged.
- R9: A static write (`st_valid`=1, `st_del`=0) stores the given mask, sets the static flag, and sets age 2'b10. If the key is already present, the write goes into that existing slot. Otherwise it takes a slot the same way a learn does. Learning a key held by a protected entry leaves that entry unchanged.
- R10: A delete (`st_valid`=1, `st_del`=1) frees the entry that matches the key only if its static flag is set. A delete aimed at a learned entry has no effect.
- R11: At most one table operation takes effect per cycle. The priority is static write/delete, then fast-age, then learn, then age tick. Lower-priority requests in that cycle are dropped.
- R12: A lookup sees the table as it was before the update made at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; empties the table |
| lk_valid | input | 1 | Lookup request |
| lk_mac | input | 48 | Lookup MAC address |
| lk_vid | input | 12 | Lookup VLAN ID |
| lk_rsp | output | 1 | Lookup result valid |
| lk_miss | output | 1 | Lookup found no entry |
| lk_mask | output | NUM_PORTS | Destination port mask (all ones on miss) |
| learn_valid | input | 1 | Learn request |
| learn_mac | input | 48 | Source MAC address to learn |
| learn_vid | input | 12 | VLAN ID of the learned address |
| learn_port | input | $clog2(NUM_PORTS) | Ingress port index |
| st_valid | input | 1 | Static write or delete request |
| st_del | input | 1 | 1 selects delete, 0 selects write |
| st_mac | input | 48 | Static entry MAC address |
| st_vid | input | 12 | Static entry VLAN ID |
| st_mask | input | NUM_PORTS | Static entry port mask |
| st_auth | input | 1 | Authenticated flag stored with a static write |
| st_ipmc | input | 1 | IP-multicast flag stored with a static write |
| flush_valid | input | 1 | Fast-age request |
| flush_ports | input | NUM_PORTS | Ports whose learned entries are flushed |
| age_tick | input | 1 | Aging step request |
| ins_fail | output | 1 | Insert dropped because every slot is protected |

## Verification
A lookup result appears one edge after `lk_valid` is sampled. `ins_fail` appears one edge after the failing insert. Any table change becomes visible to a lookup presented in the cycle after the operation. The bench drives its inputs 1 ns after a rising edge and samples the outputs 1 ns after the next rising edge. It computes the expected lookup from its model state before it applies that cycle's operation to the model. This means each comparison lands on exactly the cycle in which the result is due, and a same-cycle lookup sees the old table.

// File: rtl/l2t_pkg.sv
`timescale 1ns/1ps
// Package: shared types and age-code helpers for the aging L2 table.
// Assumes a 2-bit Gray-coded age with 2'b00 meaning a free slot.
package l2t_pkg;

    localparam logic [1:0] AGE_NEW  = 2'b10;
    localparam logic [1:0] AGE_MID  = 2'b11;
    localparam logic [1:0] AGE_OLD  = 2'b01;
    localparam logic [1:0] AGE_FREE = 2'b00;

    typedef struct packed {
        logic [47:0] mac;
        logic [11:0] vid;
    } l2_key_t;

    typedef struct packed {
        logic stat;
        logic auth;
        logic ipmc;
    } prot_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_STWR,
        OP_DEL,
        OP_FLUSH,
        OP_LEARN,
        OP_AGE
    } op_e;

    // Next code on an aging step; the free code stays free.
    function automatic logic [1:0] age_next(input logic [1:0] a);
        case (a)
            AGE_NEW: age_next = AGE_MID;
            AGE_MID: age_next = AGE_OLD;
            default: age_next = AGE_FREE;
        endcase
    endfunction

    // Replacement rank: 0 for free, rising toward the newest code.
    function automatic logic [1:0] age_rank(input logic [1:0] a);
        case (a)
            AGE_FREE: age_rank = 2'd0;
            AGE_OLD:  age_rank = 2'd1;
            AGE_MID:  age_rank = 2'd2;
            default:  age_rank = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/l2t_op_arb.sv
`timescale 1ns/1ps
// Module: picks the single table operation for this cycle.
// Assumes any request may arrive together with any other; the
// fixed order is static/delete, fast-age, learn, age tick.
module l2t_op_arb
    import l2t_pkg::*;
(
    input  logic st_valid,
    input  logic st_del,
    input  logic flush_valid,
    input  logic learn_valid,
    input  logic age_tick,
    output op_e  op
);

    // Fixed-priority choice among the pending requests.
    always_comb begin
        op = OP_NONE;
        if (st_valid)         op = st_del ? OP_DEL : OP_STWR;
        else if (flush_valid) op = OP_FLUSH;
        else if (learn_valid) op = OP_LEARN;
        else if (age_tick)    op = OP_AGE;
    end

endmodule

// File: rtl/l2t_match.sv
`timescale 1ns/1ps
// Module: parallel key compare across all entries.
// Assumes keys are unique among live entries; reports the lowest
// matching index if that ever does not hold.
module l2t_match
    import l2t_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  l2_key_t          key,
    input  l2_key_t          ent_key [N],
    input  logic [N-1:0]     ent_live,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = ent_live[g] && (ent_key[g] == key);
    end

    // Priority encode the compare vector, lowest index first.
    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/l2t_victim.sv
`timescale 1ns/1ps
// Module: chooses the slot a new key will occupy.
// Free slots rank lowest, then older age codes; protected slots are
// never candidates. Ties go to the lowest index.
module l2t_victim
    import l2t_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [1:0]       ent_age [N],
    input  logic [N-1:0]     ent_prot,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    logic [2:0] best;

    // Linear scan keeping the strictly smallest rank seen so far.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = 3'd4;
        for (int i = 0; i < N; i++) begin
            if (!ent_prot[i] && ({1'b0, age_rank(ent_age[i])} < best)) begin
                best  = {1'b0, age_rank(ent_age[i])};
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/l2_age_table.sv
`timescale 1ns/1ps
// Module: fully associative L2 address table with Gray-coded aging.
// Holds NUM_ENTRIES entries of {MAC, VLAN} -> port mask. It applies at
// most one table operation per cycle, and lookups are registered and
// read the table before that cycle's update. Assumes NUM_PORTS >= 2 and
// NUM_ENTRIES a power of two.
module l2_age_table
    import l2t_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int NUM_PORTS   = 4,
    localparam int PORT_W     = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic [47:0]          lk_mac,
    input  logic [11:0]          lk_vid,
    output logic                 lk_rsp,
    output logic                 lk_miss,
    output logic [NUM_PORTS-1:0] lk_mask,
    input  logic                 learn_valid,
    input  logic [47:0]          learn_mac,
    input  logic [11:0]          learn_vid,
    input  logic [PORT_W-1:0]    learn_port,
    input  logic                 st_valid,
    input  logic                 st_del,
    input  logic [47:0]          st_mac,
    input  logic [11:0]          st_vid,
    input  logic [NUM_PORTS-1:0] st_mask,
    input  logic                 st_auth,
    input  logic                 st_ipmc,
    input  logic                 flush_valid,
    input  logic [NUM_PORTS-1:0] flush_ports,
    input  logic                 age_tick,
    output logic                 ins_fail
);

    localparam int N     = NUM_ENTRIES;
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [NUM_PORTS-1:0] PORT_ONE = NUM_PORTS'(1);

    l2_key_t              key_q  [N];
    logic [NUM_PORTS-1:0] mask_q [N];
    logic [1:0]           age_q  [N];
    prot_t                prot_q [N];

    logic [N-1:0] live, prot_any;
    op_e          op;
    l2_key_t      lk_key, ins_key;
    logic         lk_hit, ins_hit, vic_found;
    logic [IDX_W-1:0] lk_idx, ins_idx, vic_idx, slot;
    logic         slot_ok;
    logic [NUM_PORTS-1:0] learn_mask;

    for (genvar g = 0; g < N; g++) begin : g_state
        assign live[g]     = (age_q[g] != AGE_FREE);
        assign prot_any[g] = |prot_q[g];
    end

    assign lk_key     = '{mac: lk_mac, vid: lk_vid};
    assign ins_key    = st_valid ? '{mac: st_mac, vid: st_vid}
                                 : '{mac: learn_mac, vid: learn_vid};
    assign learn_mask = PORT_ONE << learn_port;
    assign slot       = ins_hit ? ins_idx : vic_idx;
    assign slot_ok    = ins_hit || vic_found;

    l2t_op_arb u_arb (
        .st_valid    (st_valid),
        .st_del      (st_del),
        .flush_valid (flush_valid),
        .learn_valid (learn_valid),
        .age_tick    (age_tick),
        .op          (op)
    );

    l2t_match #(.N(N)) u_lk_match (
        .key      (lk_key),
        .ent_key  (key_q),
        .ent_live (live),
        .hit      (lk_hit),
        .idx      (lk_idx)
    );

    l2t_match #(.N(N)) u_ins_match (
        .key      (ins_key),
        .ent_key  (key_q),
        .ent_live (live),
        .hit      (ins_hit),
        .idx      (ins_idx)
    );

    l2t_victim #(.N(N)) u_victim (
        .ent_age  (age_q),
        .ent_prot (prot_any),
        .found    (vic_found),
        .idx      (vic_idx)
    );

    // Register the lookup result from the pre-update table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_rsp  <= 1'b0;
            lk_miss <= 1'b1;
            lk_mask <= '1;
        end else begin
            lk_rsp <= lk_valid;
            if (lk_valid) begin
                lk_miss <= !lk_hit;
                lk_mask <= lk_hit ? mask_q[lk_idx] : '1;
            end
        end
    end

    // Apply the selected table operation to the entry storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                key_q[i]  <= '0;
                mask_q[i] <= '0;
                age_q[i]  <= AGE_FREE;
                prot_q[i] <= '0;
            end
        end else begin
            case (op)
                OP_STWR: if (slot_ok) begin
                    key_q[slot]  <= ins_key;
                    mask_q[slot] <= st_mask;
                    age_q[slot]  <= AGE_NEW;
                    prot_q[slot] <= '{stat: 1'b1, auth: st_auth, ipmc: st_ipmc};
                end
                OP_DEL: if (ins_hit && prot_q[ins_idx].stat) begin
                    age_q[ins_idx]  <= AGE_FREE;
                    prot_q[ins_idx] <= '0;
                end
                OP_FLUSH: for (int i = 0; i < N; i++) begin
                    if (live[i] && !prot_any[i] && $onehot(mask_q[i])
                        && |(mask_q[i] & flush_ports))
                        age_q[i] <= AGE_FREE;
                end
                OP_LEARN: if (ins_hit) begin
                    if (!prot_any[ins_idx]) begin
                        age_q[ins_idx]  <= AGE_NEW;
                        mask_q[ins_idx] <= learn_mask;
                    end
                end else if (vic_found) begin
                    key_q[vic_idx]  <= ins_key;
                    mask_q[vic_idx] <= learn_mask;
                    age_q[vic_idx]  <= AGE_NEW;
                    prot_q[vic_idx] <= '0;
                end
                OP_AGE: for (int i = 0; i < N; i++) begin
                    if (live[i] && !prot_any[i]) age_q[i] <= age_next(age_q[i]);
                end
                default: ;
            endcase
        end
    end

    // Flag an insert that found neither its key nor a usable slot.
    always_ff @(posedge clk) begin
        if (!rst_n) ins_fail <= 1'b0;
        else        ins_fail <= ((op == OP_LEARN) || (op == OP_STWR)) && !slot_ok;
    end

    // R1
    lk_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_rsp);

    // R2
    flood_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (&lk_mask));

    // R7
    full_prot_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LEARN && !ins_hit && (&prot_any)) |=> ins_fail);

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R5
        age_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_AGE && age_q[g] == AGE_NEW && !prot_any[g])
            |=> (age_q[g] == AGE_MID));

        // R7
        prot_keeps_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
            prot_any[g] |-> (age_q[g] == AGE_NEW));

        // R10
        free_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q[g] == AGE_FREE) |-> (prot_q[g] == '0));
    end

endmodule

// File: tb/sim_l2_age_table.sv
`timescale 1ns/1ps
module sim_l2_age_table;

    localparam int CLK_PERIOD = 10;
    localparam int NE = 8;
    localparam int NP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 0, learn_valid = 0, st_valid = 0, st_del = 0;
    logic st_auth = 0, st_ipmc = 0, flush_valid = 0, age_tick = 0;
    logic [47:0] lk_mac = '0, learn_mac = '0, st_mac = '0;
    logic [11:0] lk_vid = '0, learn_vid = '0, st_vid = '0;
    logic [1:0]  learn_port = '0;
    logic [NP-1:0] st_mask = '0, flush_ports = '0;
    logic lk_rsp, lk_miss, ins_fail;
    logic [NP-1:0] lk_mask;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model state
    logic [47:0] m_mac [NE];
    logic [11:0] m_vid [NE];
    logic [NP-1:0] m_mask [NE];
    logic [1:0]  m_age [NE];
    bit          m_prot [NE];
    bit          m_stat [NE];

    always #(CLK_PERIOD/2) clk = ~clk;

    l2_age_table #(.NUM_ENTRIES(NE), .NUM_PORTS(NP)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_mac(lk_mac), .lk_vid(lk_vid),
        .lk_rsp(lk_rsp), .lk_miss(lk_miss), .lk_mask(lk_mask),
        .learn_valid(learn_valid), .learn_mac(learn_mac), .learn_vid(learn_vid),
        .learn_port(learn_port),
        .st_valid(st_valid), .st_del(st_del), .st_mac(st_mac), .st_vid(st_vid),
        .st_mask(st_mask), .st_auth(st_auth), .st_ipmc(st_ipmc),
        .flush_valid(flush_valid), .flush_ports(flush_ports),
        .age_tick(age_tick), .ins_fail(ins_fail)
    );

    function automatic logic [47:0] kmac(input int k);
        return 48'h02AB_0000_0000 + 48'(k);
    endfunction

    function automatic int m_find(input logic [47:0] mac, input logic [11:0] vid);
        for (int i = 0; i < NE; i++)
            if (m_age[i] != 2'b00 && m_mac[i] == mac && m_vid[i] == vid) return i;
        return -1;
    endfunction

    function automatic int m_rank(input logic [1:0] a);
        case (a)
            2'b00: return 0;
            2'b01: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int m_victim();
        int best = 4;
        int v = -1;
        for (int i = 0; i < NE; i++)
            if (!m_prot[i] && m_rank(m_age[i]) < best) begin
                best = m_rank(m_age[i]);
                v = i;
            end
        return v;
    endfunction

    function automatic logic [1:0] m_next(input logic [1:0] a);
        case (a)
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    task automatic m_reset();
        for (int i = 0; i < NE; i++) begin
            m_mac[i] = '0; m_vid[i] = '0; m_mask[i] = '0;
            m_age[i] = 2'b00; m_prot[i] = 0; m_stat[i] = 0;
        end
    endtask

    // Apply this cycle's request to the model; returns the expected fail flag.
    task automatic m_step(output bit fail);
        int h, v;
        fail = 0;
        if (st_valid) begin
            h = m_find(st_mac, st_vid);
            if (st_del) begin
                if (h >= 0 && m_stat[h]) begin m_age[h] = 2'b00; m_prot[h] = 0; m_stat[h] = 0; end
            end else begin
                v = (h >= 0) ? h : m_victim();
                if (v >= 0) begin
                    m_mac[v] = st_mac; m_vid[v] = st_vid; m_mask[v] = st_mask;
                    m_age[v] = 2'b10; m_prot[v] = 1; m_stat[v] = 1;
                end else fail = 1;
            end
        end else if (flush_valid) begin
            for (int i = 0; i < NE; i++)
                if (m_age[i] != 2'b00 && !m_prot[i] && $countones(m_mask[i]) == 1
                    && (m_mask[i] & flush_ports) != 0) m_age[i] = 2'b00;
        end else if (learn_valid) begin
            h = m_find(learn_mac, learn_vid);
            if (h >= 0) begin
                if (!m_prot[h]) begin m_age[h] = 2'b10; m_mask[h] = NP'(1) << learn_port; end
            end else begin
                v = m_victim();
                if (v >= 0) begin
                    m_mac[v] = learn_mac; m_vid[v] = learn_vid; m_mask[v] = NP'(1) << learn_port;
                    m_age[v] = 2'b10; m_prot[v] = 0; m_stat[v] = 0;
                end else fail = 1;
            end
        end else if (age_tick) begin
            for (int i = 0; i < NE; i++)
                if (m_age[i] != 2'b00 && !m_prot[i]) m_age[i] = m_next(m_age[i]);
        end
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        lk_valid = 0; learn_valid = 0; st_valid = 0; st_del = 0;
        flush_valid = 0; age_tick = 0; st_auth = 0; st_ipmc = 0;
    endtask

    // One cycle: expected lookup from the pre-update model, then compare after the edge.
    task automatic tick(input string tag);
        bit e_rsp, e_miss, e_fail;
        logic [NP-1:0] e_mask;
        int h;
        e_rsp = lk_valid;
        h = m_find(lk_mac, lk_vid);
        e_miss = (h < 0);
        e_mask = (h < 0) ? '1 : m_mask[h];
        m_step(e_fail);
        @(posedge clk); #1;
        chk(tag, lk_rsp, e_rsp);
        if (e_rsp) begin
            chk(tag, lk_miss, e_miss);
            chk(tag, lk_mask, e_mask);
        end
        chk("R7 ins_fail", ins_fail, e_fail);
        clear_inputs();
    endtask

    task automatic do_reset();
        rst_n = 0; clear_inputs();
        repeat (3) @(posedge clk);
        #1; rst_n = 1; m_reset();
    endtask

    task automatic probe(input int k, input logic [11:0] vid, input bit emiss,
                         input logic [NP-1:0] emask, input string tag);
        lk_valid = 1; lk_mac = kmac(k); lk_vid = vid;
        tick(tag);
        chk(tag, lk_miss, emiss);
        chk(tag, lk_mask, emask);
    endtask

    task automatic do_learn(input int k, input int port);
        learn_valid = 1; learn_mac = kmac(k); learn_vid = 12'd5; learn_port = 2'(port);
        tick("R3 learn");
    endtask

    task automatic do_static(input int k, input logic [NP-1:0] m);
        st_valid = 1; st_del = 0; st_mac = kmac(k); st_vid = 12'd5; st_mask = m;
        st_auth = 1; tick("R9 static");
    endtask

    task automatic do_delete(input int k);
        st_valid = 1; st_del = 1; st_mac = kmac(k); st_vid = 12'd5;
        tick("R10 delete");
    endtask

    task automatic do_age();
        age_tick = 1; tick("R5 age");
    endtask

    task automatic do_flush(input logic [NP-1:0] p);
        flush_valid = 1; flush_ports = p; tick("R8 flush");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        m_reset();
        do_reset();
        // Reset state
        chk("R1 reset rsp", lk_rsp, 0);
        chk("R7 reset fail", ins_fail, 0);
        probe(1, 12'd5, 1, 4'hF, "R2 empty");

        // R3 / R1 learn and key match
        do_learn(1, 2);
        probe(1, 12'd5, 0, 4'b0100, "R3 new entry");
        probe(1, 12'd6, 1, 4'hF, "R1 vid mismatch");
        // R4 refresh with port move
        do_learn(1, 1);
        probe(1, 12'd5, 0, 4'b0010, "R4 refresh");
        // R5 age sequence
        do_age(); do_age();
        probe(1, 12'd5, 0, 4'b0010, "R5 two ticks");
        do_age();
        probe(1, 12'd5, 1, 4'hF, "R5 third tick frees");

        // R9 / R7 static entry
        do_static(20, 4'b0101);
        do_age(); do_age(); do_age(); do_age();
        probe(20, 12'd5, 0, 4'b0101, "R7 static never ages");
        do_learn(20, 3);
        probe(20, 12'd5, 0, 4'b0101, "R9 learn on static");
        do_flush(4'hF);
        probe(20, 12'd5, 0, 4'b0101, "R7 static not flushed");

        // R8 fast-age
        do_learn(2, 0); do_learn(3, 1);
        do_flush(4'b0001);
        probe(2, 12'd5, 1, 4'hF, "R8 flushed port");
        probe(3, 12'd5, 0, 4'b0010, "R8 other port kept");

        // R10 delete
        do_delete(3);
        probe(3, 12'd5, 0, 4'b0010, "R10 delete learned ignored");
        do_delete(20);
        probe(20, 12'd5, 1, 4'hF, "R10 delete static");

        // R6 replacement order
        do_reset();
        for (int k = 0; k < NE; k++) do_learn(100 + k, 0);
        do_age();
        do_learn(108, 3);
        probe(100, 12'd5, 1, 4'hF, "R6 lowest index tie");
        probe(108, 12'd5, 0, 4'b1000, "R6 new key placed");
        do_learn(101, 0);
        do_age();
        do_learn(109, 2);
        probe(102, 12'd5, 1, 4'hF, "R6 oldest replaced");
        probe(103, 12'd5, 0, 4'b0001, "R6 others kept");
        probe(109, 12'd5, 0, 4'b0100, "R6 new key placed");

        // R7 all slots protected
        do_reset();
        for (int k = 0; k < NE; k++) do_static(200 + k, 4'b0011);
        learn_valid = 1; learn_mac = kmac(250); learn_vid = 12'd5; learn_port = 2'd1;
        tick("R7 full learn");
        chk("R7 fail pulse", ins_fail, 1);
        tick("R7 idle");
        chk("R7 fail one cycle", ins_fail, 0);
        probe(250, 12'd5, 1, 4'hF, "R7 dropped learn");

        // R11 priority and R12 same-cycle lookup
        do_reset();
        st_valid = 1; st_mac = kmac(30); st_vid = 12'd5; st_mask = 4'b1001;
        learn_valid = 1; learn_mac = kmac(31); learn_vid = 12'd5; learn_port = 2'd0;
        tick("R11 static over learn");
        probe(30, 12'd5, 0, 4'b1001, "R11 static applied");
        probe(31, 12'd5, 1, 4'hF, "R11 learn dropped");
        lk_valid = 1; lk_mac = kmac(32); lk_vid = 12'd5;
        learn_valid = 1; learn_mac = kmac(32); learn_vid = 12'd5; learn_port = 2'd3;
        tick("R12 same cycle");
        chk("R12 old table", lk_miss, 1);
        probe(32, 12'd5, 0, 4'b1000, "R12 next cycle");

        // Constrained random phase
        do_reset();
        void'($urandom(32'd1234));
        for (int c = 0; c < 4000; c++) begin
            int r;
            r = int'($urandom % 100);
            lk_valid = ($urandom % 4) != 0;
            lk_mac = kmac(int'($urandom % 14)); lk_vid = 12'(5 + $urandom % 2);
            if (r < 5) begin
                st_valid = 1; st_del = ($urandom % 2) == 1;
                st_mac = kmac(int'($urandom % 14)); st_vid = 12'(5 + $urandom % 2);
                st_mask = 4'($urandom); st_ipmc = ($urandom % 2) == 1;
            end
            if (r >= 5 && r < 12) begin
                flush_valid = 1; flush_ports = 4'($urandom);
            end
            if (r >= 10 && r < 60) begin
                learn_valid = 1; learn_mac = kmac(int'($urandom % 14));
                learn_vid = 12'(5 + $urandom % 2); learn_port = 2'($urandom);
            end
            if (r >= 55 && r < 75) age_tick = 1;
            tick("R1 random lookup");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule